// File: doc/BRIEF.md
# Execution-Count Break Qualifier

This block sits behind a debug channel's comparator logic and decides when a match of that channel should raise a break request. Software loads a repeat count into a 16-bit register. With count mode enabled, each incoming match lowers the count by one. The break request is raised by the match that arrives while the count already stands at one. A loaded count of zero behaves like one. When the count has fired, it stays at one until software writes a new value.

With count mode disabled, every match raises a break at once and the register keeps its value. The break request is a registered pulse that comes one clock after the qualifying match. A two-state machine produces it: `ST_QUIET` (no request) and `ST_BREAK` (request high for this cycle). The transitions are:
- `QUIET->BREAK`: a qualifying match.
- `BREAK->BREAK`: another qualifying match in the very next cycle.
- `BREAK->QUIET`: any cycle without a qualifying match.
- `QUIET->QUIET`: likewise, any cycle without a qualifying match.

Software reads the register at any time over a simple write/read port.

Top module: `exc_brk_counter`

## Requirements
- R1: Bits 15..12 of `reg_rdata` always read 0, whatever value was written to them.
- R2: A write stores `reg_wdata[11:0]` as the count, readable on `reg_rdata[11:0]` in the next cycle; values 0 through 4095 are held exactly.
- R3: With `cnt_mode` high and no write, a `match` while the count is above 1 lowers the count by exactly one and raises no break.
- R4: With `cnt_mode` high, a `match` while the count is 1 or 0 raises a break and leaves the count unchanged, so a loaded count N (N>=1) breaks on match number N and a loaded 0 breaks on the first match.
- R5: After reset the count reads 0 and `brk_req` is low.
- R6: With `cnt_mode` low, every `match` raises a break and the count is not changed.
- R7: `brk_req` is high exactly in the cycle after a qualifying match and low in every other cycle; back-to-back qualifying matches give back-to-back pulses.
- R8: A write in the same cycle as a `match` stores the written value instead of the decrement; whether that match breaks is decided from the count held before the write.
- R9: Cycles without a `match` or a write leave the count unchanged and raise no break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data; upper four bits discarded |
| reg_rdata | output | 16 | Current register contents |
| cnt_mode | input | 1 | 1: count matches before breaking; 0: break on every match |
| match | input | 1 | One-cycle channel condition-match strobe |
| brk_req | output | 1 | Break request pulse, one cycle after a qualifying match |

## Verification
The hardest situation to reach is a match that lands in the same cycle as a register write while the count sits at the firing threshold. The bench first walks a count down to one with single matches, and then drives a match together with a write. It checks that the break still fires and that the written value survives. The sweep covers every loaded count from 0 to 20 plus the 4095 maximum. For each one it checks the readback after every match and the exact match number that breaks, and it computes both from the loaded value.

// File: rtl/exc_brk_pkg.sv
package exc_brk_pkg;

    localparam int unsigned REG_W = 16;
    localparam int unsigned CNT_W = 12;

    typedef enum logic [0:0] {
        ST_QUIET = 1'b0,
        ST_BREAK = 1'b1
    } brk_state_t;

endpackage

// File: rtl/exc_cnt_reg.sv
module exc_cnt_reg #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;

    // Software write outranks the hardware decrement.
    always_comb begin
        cnt_nxt = cnt;
        if (wr_en) begin
            cnt_nxt = wr_val;
        end else if (dec) begin
            cnt_nxt = cnt - STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/exc_cnt_qual.sv
module exc_cnt_qual #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             match,
    input  logic             cnt_mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             fire,
    output logic             dec
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic at_last;

    // A count of zero is treated the same as one.
    assign at_last = (cnt <= LAST);

    always_comb begin
        fire = 1'b0;
        dec  = 1'b0;
        if (match) begin
            if (!cnt_mode || at_last) begin
                fire = 1'b1;
            end else begin
                dec = 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_brk_fsm.sv
module exc_brk_fsm
    import exc_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic brk_req
);

    brk_state_t state_q;
    brk_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: state_d = fire ? ST_BREAK : ST_QUIET;
            ST_BREAK: state_d = fire ? ST_BREAK : ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        brk_req = 1'b0;
        unique case (state_q)
            ST_QUIET: brk_req = 1'b0;
            ST_BREAK: brk_req = 1'b1;
            default:  brk_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/exc_brk_counter.sv
module exc_brk_counter
    import exc_brk_pkg::*;
#(
    parameter int unsigned P_REG_W = REG_W,
    parameter int unsigned P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [P_REG_W-1:0] reg_wdata,
    output logic [P_REG_W-1:0] reg_rdata,
    input  logic               cnt_mode,
    input  logic               match,
    output logic               brk_req
);

    localparam int unsigned PAD_W = P_REG_W - P_CNT_W;

    logic [P_CNT_W-1:0] cnt;
    logic               fire;
    logic               dec;
    logic               unused_hi;

    assign unused_hi = ^reg_wdata[P_REG_W-1:P_CNT_W];

    exc_cnt_reg #(.CNT_W(P_CNT_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .wr_val (reg_wdata[P_CNT_W-1:0]),
        .dec    (dec),
        .cnt    (cnt)
    );

    exc_cnt_qual #(.CNT_W(P_CNT_W)) u_qual (
        .match    (match),
        .cnt_mode (cnt_mode),
        .cnt      (cnt),
        .fire     (fire),
        .dec      (dec)
    );

    exc_brk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .brk_req (brk_req)
    );

    assign reg_rdata = {{PAD_W{1'b0}}, cnt};

endmodule

// File: rtl/exc_brk_chk.sv
module exc_brk_chk #(
    parameter int unsigned P_REG_W = 16,
    parameter int unsigned P_CNT_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [P_REG_W-1:0] reg_wdata,
    input logic [P_REG_W-1:0] reg_rdata,
    input logic               cnt_mode,
    input logic               match,
    input logic               brk_req
);

    localparam logic [P_CNT_W-1:0] ONE = P_CNT_W'(1);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[P_REG_W-1:P_CNT_W] == '0);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_rdata[P_CNT_W-1:0] == $past(reg_wdata[P_CNT_W-1:0]));

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (match && cnt_mode && !reg_we && reg_rdata[P_CNT_W-1:0] > ONE)
        |=> (reg_rdata[P_CNT_W-1:0] == $past(reg_rdata[P_CNT_W-1:0]) - ONE) && !brk_req);

    a_r4_fire_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (match && cnt_mode && !reg_we && reg_rdata[P_CNT_W-1:0] <= ONE)
        |=> brk_req && $stable(reg_rdata));

    a_r6_direct_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cnt_mode && !reg_we) |=> brk_req && $stable(reg_rdata));

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> !brk_req);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !reg_we) |=> $stable(reg_rdata));

endmodule

bind exc_brk_counter exc_brk_chk #(.P_REG_W(P_REG_W), .P_CNT_W(P_CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cnt_mode  (cnt_mode),
    .match     (match),
    .brk_req   (brk_req)
);

// File: tb/exc_brk_counter_tb.sv
module exc_brk_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cnt_mode = 1'b0;
    logic        match = 1'b0;
    logic        brk_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    exc_brk_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt_mode  (cnt_mode),
        .match     (match),
        .brk_req   (brk_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock cycle with given strobes; outputs are sampled at the following negedge.
    task automatic step(input bit m, input bit we, input int wd);
        match     = m;
        reg_we    = we;
        reg_wdata = 16'(wd);
        @(negedge clk);
        match     = 1'b0;
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic load(input int v);
        step(1'b0, 1'b1, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_fire;
        repeat (3) @(negedge clk);
        // R5: reset values
        check("R5 count", int'(reg_rdata), 0);
        check("R5 brk", int'(brk_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reserved bits discard writes
        load(16'hFFFF);
        check("R1 upper", int'(reg_rdata[15:12]), 0);
        check("R2 max", int'(reg_rdata[11:0]), 4095);
        load(16'hA123);
        check("R1 upper mixed", int'(reg_rdata), 16'h0123);

        // R2: write pattern sweep over single bits
        for (int b = 0; b < 12; b++) begin
            load(1 << b);
            check("R2 bit", int'(reg_rdata), 1 << b);
        end

        // R9: idle cycles change nothing
        load(37);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, 0);
            check("R9 count", int'(reg_rdata), 37);
            check("R9 brk", int'(brk_req), 0);
        end

        // R3/R4/R7: sweep loaded counts in count mode
        cnt_mode = 1'b1;
        for (int n = 0; n <= 20; n++) begin
            load(n);
            exp_fire = (n == 0) ? 1 : n;
            for (int k = 1; k <= exp_fire + 1; k++) begin
                step(1'b1, 1'b0, 0);
                if (k < exp_fire) begin
                    check("R3 count", int'(reg_rdata), n - k);
                    check("R3 no brk", int'(brk_req), 0);
                end else begin
                    check("R4 brk", int'(brk_req), 1);
                    check("R4 hold", int'(reg_rdata), (n == 0) ? 0 : 1);
                end
                step(1'b0, 1'b0, 0);
                check("R7 pulse end", int'(brk_req), 0);
            end
        end

        // R4: maximum count
        load(4095);
        for (int k = 1; k < 4095; k++) step(1'b1, 1'b0, 0);
        check("R3 max walk", int'(reg_rdata), 1);
        check("R3 max no brk", int'(brk_req), 0);
        step(1'b1, 1'b0, 0);
        check("R4 max brk", int'(brk_req), 1);

        // R7: back-to-back qualifying matches
        load(1);
        step(1'b1, 1'b0, 0);
        check("R7 first", int'(brk_req), 1);
        step(1'b1, 1'b0, 0);
        check("R7 second", int'(brk_req), 1);
        step(1'b0, 1'b0, 0);
        check("R7 drop", int'(brk_req), 0);

        // R8: write with match above threshold
        load(5);
        step(1'b1, 1'b1, 9);
        check("R8 write wins", int'(reg_rdata), 9);
        check("R8 no brk", int'(brk_req), 0);
        // R8: write with match at threshold
        load(2);
        step(1'b1, 1'b0, 0);
        check("R8 walk", int'(reg_rdata), 1);
        step(1'b1, 1'b1, 7);
        check("R8 brk old count", int'(brk_req), 1);
        check("R8 written", int'(reg_rdata), 7);

        // R6: count mode off
        cnt_mode = 1'b0;
        load(5);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, 0);
            check("R6 brk", int'(brk_req), 1);
            check("R6 count", int'(reg_rdata), 5);
        end
        step(1'b0, 1'b0, 0);
        check("R6 drop", int'(brk_req), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule